// File: doc/BRIEF.md
# Repeated-Bit Serial Detector

This block watches a single-bit serial stream and flags every bit that repeats the one before it. The flag therefore stays high through any run of two or more equal bits, whether the run is of zeros or of ones. A small three-state machine remembers the last bit seen. Its start state stands for "no bit yet", so the first bit after reset can never match.

The stream source changes the data on the falling clock edge. The block captures the data on the rising edge. The flag is a registered Mealy output: it is computed from the current state and the incoming bit, and loaded on the same rising edge that moves the state. It then stays steady for a whole cycle. Reset is synchronous and active-low. It returns the machine to the start state and clears the flag.

Top module: `rep_bit_detect`

## Requirements
- R1: While `rst_n` is low at a rising edge, `run_hit` is 0 after that edge and the machine returns to its start state.
- R2: The first bit captured after reset always gives `run_hit` = 0, whatever its value.
- R3: A 0 captured right after a captured 0 sets `run_hit` to 1 after that rising edge.
- R4: A 1 captured right after a captured 1 sets `run_hit` to 1 after that rising edge.
- R5: A bit that differs from the previously captured bit gives `run_hit` = 0 after that rising edge.
- R6: During a run of N equal bits, `run_hit` is 1 for each of the last N-1 bits of the run.
- R7: The state register always holds exactly one active bit once reset has been applied. The bits stand for start, last-was-0 and last-was-1, at positions 0, 1 and 2.
- R8: A reset in the middle of a run clears the memory of the last bit, so the next bit does not match the bit captured before the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the data is sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Serial data bit, changed on the falling edge |
| run_hit | output | 1 | Registered flag: the captured bit equals the previous one |

## Verification
The assertions assume that `ser_in` is stable around each rising edge, since it changes only on the falling edge. They also assume that reset is held low for at least one rising edge before checking starts. The bench drives every bit and every change of `rst_n` on the falling edge, and it starts with several reset cycles. It reads `run_hit` at the next falling edge, half a cycle after the capturing edge. It compares the flag with a model of the previous bit, which forgets that bit on reset.

// File: rtl/rbd_pkg.sv
// Package: shared state encoding for the repeated-bit detector.
// Assumes one-hot state coding; each index names one flip-flop.
package rbd_pkg;
    localparam int NUM_STATES = 3;
    localparam int IDX_START  = 0;
    localparam int IDX_LAST0  = 1;
    localparam int IDX_LAST1  = 2;

    typedef logic [NUM_STATES-1:0] state_t;

    localparam state_t ST_START = state_t'(1) << IDX_START;
    localparam state_t ST_LAST0 = state_t'(1) << IDX_LAST0;
    localparam state_t ST_LAST1 = state_t'(1) << IDX_LAST1;
endpackage

// File: rtl/rbd_state_reg.sv
// Module: one-hot state register.
// Loads the next state on each rising edge. A synchronous active-low
// reset forces the start state. Assumes the next state is one-hot.
module rbd_state_reg
    import rbd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  state_t nxt,
    output state_t cur
);
    // Purpose: hold the current state, with reset to start.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= ST_START;
        else        cur <= nxt;
    end
endmodule

// File: rtl/rbd_next_logic.sv
// Module: next-state and Mealy output decode.
// The next state records the incoming bit. The output is set when the
// incoming bit equals the bit recorded in a last-was state.
// Assumes the current state is one-hot.
module rbd_next_logic
    import rbd_pkg::*;
(
    input  state_t cur,
    input  logic   bit_in,
    output state_t nxt,
    output logic   hit_nxt
);
    // Purpose: select the last-was state that matches the incoming bit.
    always_comb begin
        nxt = bit_in ? ST_LAST1 : ST_LAST0;
    end

    // Purpose: flag a bit equal to the remembered one; start never matches.
    always_comb begin
        hit_nxt = (bit_in & cur[IDX_LAST1]) | (~bit_in & cur[IDX_LAST0]);
    end
endmodule

// File: rtl/rbd_out_reg.sv
// Module: output flag register.
// Loads the Mealy output on the rising edge so that the flag is steady
// for one full cycle. A synchronous active-low reset clears the flag.
module rbd_out_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    // Purpose: register the flag, with reset to 0.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= d;
    end
endmodule

// File: rtl/rep_bit_detect.sv
// Module: top of the repeated-bit serial detector.
// Assumes ser_in changes on the falling edge and is sampled on the rising
// edge. Raises run_hit after each bit that equals the previous bit.
module rep_bit_detect
    import rbd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ser_in,
    output logic run_hit
);
    state_t state_q;
    state_t state_d;
    logic   hit_d;

    rbd_next_logic u_next (
        .cur     (state_q),
        .bit_in  (ser_in),
        .nxt     (state_d),
        .hit_nxt (hit_d)
    );

    rbd_state_reg u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (state_d),
        .cur   (state_q)
    );

    rbd_out_reg u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (hit_d),
        .q     (run_hit)
    );
endmodule

// File: rtl/rbd_checker.sv
// Module: property checker for rep_bit_detect, attached by bind.
// Assumes ser_in is stable around each rising edge.
module rbd_checker
    import rbd_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   ser_in,
    input logic   run_hit,
    input state_t state
);
    // R1: reset clears the flag and returns the machine to start
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!run_hit && state == ST_START));

    // R2: no match is possible from the start state
    assert_first_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state[IDX_START] |=> !run_hit);

    // R3: a repeated 0 raises the flag
    assert_zero_repeat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state[IDX_LAST0] && !ser_in) |=> run_hit);

    // R4: a repeated 1 raises the flag
    assert_one_repeat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state[IDX_LAST1] && ser_in) |=> run_hit);

    // R5: a change of bit value clears the flag
    assert_change_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state[IDX_LAST0] && ser_in) || (state[IDX_LAST1] && !ser_in)) |=> !run_hit);

    // R7: exactly one state bit is active
    assert_one_hot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state) == 1);
endmodule

bind rep_bit_detect rbd_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ser_in  (ser_in),
    .run_hit (run_hit),
    .state   (state_q)
);

// File: tb/tb_rep_bit_detect.sv
`timescale 1ns/1ps
module tb_rep_bit_detect;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_in = 1'b0;
    logic run_hit;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    // Model state: the previous captured bit and whether it is valid
    bit prev_ok = 1'b0;
    bit prev_bit = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    rep_bit_detect dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_in  (ser_in),
        .run_hit (run_hit)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: run_hit=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a falling edge: drives the bit, waits one cycle, checks
    task automatic send_bit(input bit b, input string scen);
        bit exp;
        string req;
        exp = prev_ok && (prev_bit == b);
        if (!prev_ok)     req = "R2";
        else if (exp)     req = b ? "R4" : "R3";
        else              req = "R5";
        ser_in = b;
        @(negedge clk);
        check({req, " ", scen}, run_hit, exp);
        prev_ok = 1'b1;
        prev_bit = b;
    endtask

    task automatic do_reset(input int cycles);
        rst_n = 1'b0;
        repeat (cycles) @(negedge clk);
        check("R1 reset", run_hit, 1'b0);
        rst_n = 1'b1;
        prev_ok = 1'b0;
    endtask

    task automatic test_zero_run();
        do_reset(2);
        for (int i = 0; i < 6; i++) send_bit(1'b0, "R6 zero run");
    endtask

    task automatic test_one_run();
        do_reset(2);
        for (int i = 0; i < 6; i++) send_bit(1'b1, "R6 one run");
    endtask

    task automatic test_alternate();
        do_reset(2);
        for (int i = 0; i < 8; i++) send_bit(i[0], "alternating");
    endtask

    task automatic test_mixed();
        bit [15:0] pat = 16'b1100_1110_0010_1101;
        do_reset(1);
        for (int i = 0; i < 16; i++) send_bit(pat[i], "mixed");
    endtask

    task automatic test_reset_mid_run();
        do_reset(2);
        send_bit(1'b1, "R8 pre");
        send_bit(1'b1, "R8 pre");
        do_reset(1);
        send_bit(1'b1, "R8 after reset");
        send_bit(1'b1, "R8 after reset");
        do_reset(1);
        send_bit(1'b0, "R8 zero start");
        send_bit(1'b0, "R8 zero start");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        do_reset(3);
        test_zero_run();
        test_one_run();
        test_alternate();
        test_mixed();
        test_reset_mid_run();
        finish_run();
    end

    initial begin
        #800000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run_hit=%b expected=finished", run_hit);
        finish_run();
    end
endmodule